// File: doc/BRIEF.md
# Compare-Match PWM Timer Channel

This block is a 16-bit up-counting timer channel that turns a set of compare registers into PWM waveforms, one output pin per compare register. Software-side logic loads each register with a compare value and two pin actions: one applied when the counter matches that register, and one applied at every period boundary. Each action is hold, drive low, drive high or toggle.

Any one of the compare registers can be picked as the period source. When the counter reaches that register's value, it returns to zero on the next clock. The other registers then place the waveform edges inside the period. Duty cycle runs from 0% to 100%. A compare value above the period value never matches, and when a match lands on the boundary cycle the boundary action wins.

Writes go to shadow copies. While the channel is counting, they reach the live registers only at the next period boundary, so a period in progress is never cut short or given an extra edge. Several channels can run in step: they share the run input, and an external clear strobe is honoured by every channel that has it enabled.

Top module: `pwm_cmp_chan`

## Requirements
- R1: While `rst` is high, the channel clears on each clock edge: `count` goes to 0, every `pwm_out` bit goes to 0, every compare value goes to all ones and every action goes to hold.
- R2: With `run` high and no clear, `count` rises by one per clock. With `run` low it holds its value, and the pins hold theirs.
- R3: When `count` equals the value of the register chosen by `clr_sel` while running, the next clock sets `count` to 0, giving a period of value+1 clocks.
- R4: When `count` equals compare value i while running (and it is not a boundary cycle), on the next clock `pwm_out[i]` takes its match action. Action codes are 2'b00 hold, 2'b01 drive 0, 2'b10 drive 1, 2'b11 toggle.
- R5: On a boundary cycle (R3), on the next clock every `pwm_out[i]` takes its own period action, using the same codes as R4.
- R6: If a pin's match and the boundary occur in the same cycle, the period action is applied and the match action is dropped.
- R7: A compare value greater than the period value never matches, so that pin sits at a constant level: 100% duty with period action drive 1, 0% with period action drive 0.
- R8: A write (`wr_en`, `wr_idx`, `wr_val`, `wr_mact`, `wr_pact`) made while running takes effect from the first count after the next boundary. While stopped, it takes effect one clock after the write.
- R9: When `sync_clr` and `sync_en` are both high, `count` is 0 after the next clock, whether the channel is running or not. When `sync_en` is low, `sync_clr` has no effect.
- R10: Any register index may be selected through `clr_sel` as the period source. Registers that are not selected do not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable (start bit) |
| sync_clr | input | 1 | Shared clear strobe from a group of channels |
| sync_en | input | 1 | Honour `sync_clr` in this channel |
| clr_sel | input | IW | Index of the compare register that sets the period |
| wr_en | input | 1 | Write strobe for one compare register |
| wr_idx | input | IW | Index of the register written |
| wr_val | input | W | Compare value |
| wr_mact | input | 2 | Pin action on compare match |
| wr_pact | input | 2 | Pin action at the period boundary |
| count | output | W | Current counter value |
| pwm_out | output | N | One PWM pin per compare register |

## Verification
The assertions assume that `clr_sel` and `wr_idx` always name an existing register, and that `clr_sel` does not change while `run` is high. The counter-step property also relies on the period source being the only thing besides `sync_clr` that can return the count to zero. The stimulus changes `clr_sel` only while the channel is stopped and uses indices below N. Every input changes half a clock away from the sampling edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } pin_act_e;

  function automatic logic act_apply(input logic [1:0] act, input logic cur);
    unique case (pin_act_e'(act))
      ACT_LOW:  act_apply = 1'b0;
      ACT_HIGH: act_apply = 1'b1;
      ACT_TGL:  act_apply = ~cur;
      default:  act_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [W-1:0]        wr_val,
  input  logic [1:0]          wr_mact,
  input  logic [1:0]          wr_pact,
  input  logic                load,
  output logic [N-1:0][W-1:0] live_val,
  output logic [N-1:0][1:0]   live_mact,
  output logic [N-1:0][1:0]   live_pact
);
  import pwm_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] sh_val;
    logic [1:0]   sh_mact, sh_pact;
    logic         hit;

    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_val  <= '1;
        sh_mact <= ACT_HOLD;
        sh_pact <= ACT_HOLD;
      end else if (hit) begin
        sh_val  <= wr_val;
        sh_mact <= wr_mact;
        sh_pact <= wr_pact;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        live_val[g]  <= '1;
        live_mact[g] <= ACT_HOLD;
        live_pact[g] <= ACT_HOLD;
      end else if (load) begin
        live_val[g]  <= sh_val;
        live_mact[g] <= sh_mact;
        live_pact[g] <= sh_pact;
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = run && (count == period);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (clr)  count <= '0;
    else if (run)  count <= wrap ? '0 : count + W'(1);
  end
endmodule

// File: rtl/pwm_pin_ctl.sv
module pwm_pin_ctl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   mact,
  input  logic [1:0]   pact,
  output logic         pin
);
  import pwm_pkg::*;

  logic hit;
  assign hit = run && (count == cmp);

  always_ff @(posedge clk) begin
    if (rst)       pin <= 1'b0;
    else if (wrap) pin <= act_apply(pact, pin);
    else if (hit)  pin <= act_apply(mact, pin);
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          sync_clr,
  input  logic          sync_en,
  input  logic [IW-1:0] clr_sel,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic [1:0]    wr_mact,
  input  logic [1:0]    wr_pact,
  output logic [W-1:0]  count,
  output logic [N-1:0]  pwm_out
);
  logic [N-1:0][W-1:0] live_val;
  logic [N-1:0][1:0]   live_mact;
  logic [N-1:0][1:0]   live_pact;
  logic                wrap;
  logic                grp_clr;
  logic                load;
  logic [W-1:0]        period;

  assign grp_clr = sync_en && sync_clr;
  assign load    = !run || wrap || grp_clr;
  assign period  = live_val[clr_sel];

  pwm_shadow_bank #(.N(N), .W(W), .IW(IW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .wr_mact(wr_mact), .wr_pact(wr_pact),
    .load(load),
    .live_val(live_val), .live_mact(live_mact), .live_pact(live_pact)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .clr(grp_clr),
    .period(period), .count(count), .wrap(wrap)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    pwm_pin_ctl #(.W(W)) u_pin (
      .clk(clk), .rst(rst), .run(run), .wrap(wrap),
      .count(count), .cmp(live_val[g]),
      .mact(live_mact[g]), .pact(live_pact[g]),
      .pin(pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int N  = 4,
  parameter int W  = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         sync_clr,
  input logic         sync_en,
  input logic [W-1:0] count,
  input logic [N-1:0] pwm_out
);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (count == '0 && pwm_out == '0));

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !(sync_en && sync_clr)) |=> $stable(count));

  // R2
  pins_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pwm_out));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !(sync_en && sync_clr)) |=> (count == '0 || count == $past(count) + 1'b1));

  // R9
  group_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_en && sync_clr) |=> count == '0);
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .sync_clr(sync_clr), .sync_en(sync_en),
  .count(count), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_cmp_chan.sv
module sim_pwm_cmp_chan;
  localparam int N = 4;
  localparam int W = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst, run, sync_clr, sync_en, wr_en;
  logic [IW-1:0] clr_sel, wr_idx;
  logic [W-1:0]  wr_val;
  logic [1:0]    wr_mact, wr_pact;
  logic [W-1:0]  count;
  logic [N-1:0]  pwm_out;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pwm_cmp_chan #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .run(run), .sync_clr(sync_clr), .sync_en(sync_en),
    .clr_sel(clr_sel), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .wr_mact(wr_mact), .wr_pact(wr_pact), .count(count), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input int idx, input int val, input logic [1:0] ma, input logic [1:0] pa);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_val = W'(val); wr_mact = ma; wr_pact = pa;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 200 && count != W'(v); i++) @(negedge clk);
  endtask

  task automatic high_time(input int idx, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[idx]) hi++;
      @(negedge clk);
    end
  endtask

  task automatic check_wrap(input int p, input string req);
    int mx = 0;
    bit seen = 0;
    int prev;
    prev = int'(count);
    for (int i = 0; i < 2 * (p + 1) + 2; i++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
      if (prev == p && count == '0) seen = 1;
      prev = int'(count);
    end
    check(mx == p, req, mx, p);
    check(seen, req, int'(seen), 1);
  endtask

  task automatic t_reset();
    rst = 1; run = 0; sync_clr = 0; sync_en = 0; wr_en = 0;
    clr_sel = '0; wr_idx = '0; wr_val = '0; wr_mact = 2'b00; wr_pact = 2'b00;
    tick(3);
    rst = 0;
    tick(1);
    check(count == '0, "R1 count", int'(count), 0);
    check(pwm_out == '0, "R1 pins", int'(pwm_out), 0);
  endtask

  task automatic t_count_and_sync();
    int v;
    run = 1;
    tick(5);
    check(count == W'(5), "R2 counting", int'(count), 5);
    run = 0;
    tick(3);
    check(count == W'(5), "R2 hold", int'(count), 5);
    check(pwm_out == '0, "R2 pins hold", int'(pwm_out), 0);
    run = 1;
    v = int'(count);
    sync_clr = 1; sync_en = 0;
    tick(1);
    sync_clr = 0;
    check(count == W'(v + 1), "R9 ignored without enable", int'(count), v + 1);
    run = 0;
    sync_clr = 1; sync_en = 1;
    tick(1);
    sync_clr = 0; sync_en = 0;
    check(count == '0, "R9 clear while stopped", int'(count), 0);
  endtask

  task automatic t_period();
    int hi;
    write_reg(0, 9, 2'b00, 2'b11);
    write_reg(1, 3, 2'b01, 2'b10);
    write_reg(2, 20, 2'b01, 2'b10);
    write_reg(3, 50, 2'b10, 2'b01);
    run = 1;
    check_wrap(9, "R3 period wrap");
    tick(3);
    high_time(1, 10, hi);
    check(hi == 4, "R4 R5 duty", hi, 4);
    high_time(2, 10, hi);
    check(hi == 10, "R7 full duty", hi, 10);
    high_time(3, 10, hi);
    check(hi == 0, "R7 zero duty", hi, 0);
    high_time(0, 20, hi);
    check(hi == 10, "R5 toggle at boundary", hi, 10);
  endtask

  task automatic t_shadow_and_prio();
    int hi;
    wait_count(1);
    write_reg(1, 6, 2'b01, 2'b10);
    wait_count(4);
    check(pwm_out[1] == 1'b0, "R8 old value in current period", int'(pwm_out[1]), 0);
    wait_count(0);
    high_time(1, 10, hi);
    check(hi == 7, "R8 new value after boundary", hi, 7);
    write_reg(1, 9, 2'b01, 2'b10);
    tick(25);
    high_time(1, 10, hi);
    check(hi == 10, "R6 boundary action wins", hi, 10);
  endtask

  task automatic t_sync_running();
    wait_count(5);
    sync_clr = 1; sync_en = 1;
    tick(1);
    sync_clr = 0; sync_en = 0;
    check(count == '0, "R9 clear while running", int'(count), 0);
  endtask

  task automatic t_clr_select();
    run = 0;
    sync_clr = 1; sync_en = 1;
    tick(1);
    sync_clr = 0; sync_en = 0;
    clr_sel = 2'd2;
    tick(1);
    run = 1;
    check_wrap(20, "R10 register 2 as period");
    run = 0;
    clr_sel = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count_and_sync();
    t_period();
    t_shadow_and_prio();
    t_sync_running();
    t_clr_select();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule